// File: doc/BRIEF.md
# UART Receive Transfer Engine

This block receives an asynchronous serial line framed as 8 data bits, no parity and one stop bit. It oversamples the line 16 times per bit and packs the received characters into 32-bit words, four to a word. Full words go into a small receive FIFO, which software or a consumer drains with a read strobe. The first word is always visible on the read port.

Reception is organised in transfers. Writing a maximum character count arms a transfer. The transfer ends in one of two ways: the armed count is reached, or the line stays quiet for a programmed number of character times (a stale event). When a transfer ends, the block pushes any partly filled word into the FIFO, pulses a done strobe, and latches the number of valid characters into a snapshot output. Sticky status bits report overrun, framing errors and the stale event. A small command port clears these bits and resets the receive path.

Top module: `uart_rx_xfer`

## Requirements
- R1: The line is sampled with 16 ticks per bit, one tick every OSR_DIV clocks. A falling edge starts a frame, but only if the line is still low 8 ticks later (mid start bit). A shorter low pulse produces no character. Data bits are taken least significant bit first, each at its bit centre.
- R2: Characters are packed four per 32-bit word. The first character of a word goes in bits 7:0, the second in 15:8, and so on. A word is pushed once its fourth byte arrives. Unused bytes of a partial word read as zero.
- R3: A pulse on len_wr arms a transfer with the length len_val and sets the running count to zero. A character that arrives while no transfer is armed is discarded.
- R4: When the running count reaches the armed length, the transfer ends. The partial word is pushed, xfer_done pulses for exactly one cycle, and snap_count takes the length. snap_count changes only in a cycle where xfer_done is high.
- R5: With stale enabled, a nonzero stale_tmo and at least one character in the current transfer, a stale event occurs once the line has been idle for stale_tmo character times (160 ticks each), counted from the last stop-bit sample. The event sets stale_flag, ends the transfer, pushes any partial word, pulses xfer_done and latches the count into snap_count.
- R6: Commands use cmd_valid together with cmd_code. Code 4 enables stale detection and code 5 disables it; stale detection is off after reset. While it is disabled, no stale event occurs and a partial word stays unpushed.
- R7: Command code 3 clears stale_flag.
- R8: data_ready is high while the FIFO holds at least one word. rd_data shows the oldest word. rd_en pops that word when data_ready is high.
- R9: A character that arrives while the FIFO is full is discarded and sets the sticky overrun bit. Command code 2 clears the overrun bit.
- R10: A stop bit sampled low sets the sticky framing_err bit, and the character is discarded. Command code 2 clears framing_err.
- R11: Command code 1 empties the FIFO, drops any partial word and clears the running count.
- R12: After reset, data_ready, overrun, framing_err, stale_flag, xfer_done and snap_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | 1 reset receiver, 2 reset error status, 3 reset stale, 4 enable stale, 5 disable stale |
| len_wr | input | 1 | Arms a transfer |
| len_val | input | LEN_W (10) | Transfer length in characters |
| stale_tmo | input | STALE_W (4) | Stale timeout in character times, 0 disables |
| rd_en | input | 1 | Pops the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| data_ready | output | 1 | FIFO not empty |
| overrun | output | 1 | Sticky: character lost because the FIFO was full |
| framing_err | output | 1 | Sticky: stop bit was low |
| stale_flag | output | 1 | Sticky: transfer ended by idle timeout |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |
| snap_count | output | LEN_W (10) | Characters held by the last ended transfer |

## Verification
Command effects on the status bits, the FIFO and stale_flag appear one clock after the command. The bench drives commands at a falling edge and samples at the next falling edge. A character is accepted three clocks of input synchronisation after the centre of its stop bit, and done, snapshot and FIFO updates follow one clock later. The bench therefore checks only after the full stop bit has been driven, and the half bit in between covers those latencies with margin. The stale event depends on the idle count and on tick phase, so the bench brackets it: at 1000 clocks after the frame it expects stale_flag still low, and at 1400 clocks it expects it high. The nominal time is 1280 clocks.

// File: rtl/uart_rx_xfer.sv
module uart_rx_xfer #(
  parameter int OSR_DIV    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 10,
  parameter int STALE_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_code,
  input  logic               len_wr,
  input  logic [LEN_W-1:0]   len_val,
  input  logic [STALE_W-1:0] stale_tmo,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  output logic               data_ready,
  output logic               overrun,
  output logic               framing_err,
  output logic               stale_flag,
  output logic               xfer_done,
  output logic [LEN_W-1:0]   snap_count
);
  localparam int DIV_W      = $clog2(OSR_DIV + 1);
  localparam int PTR_W      = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CHAR_TICKS = 16 * 10;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_t;

  logic [2:0]       rx_sync;
  logic [DIV_W-1:0] div_cnt;
  rx_st_t           st;
  logic [3:0]       ph;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             chr_vld, ferr_evt;

  wire rx_s = rx_sync[1];
  wire fall = rx_sync[2] & ~rx_sync[1];
  wire tick = (div_cnt == DIV_W'(OSR_DIV - 1));

  wire c_rst_rx    = cmd_valid && cmd_code == 3'd1;
  wire c_rst_err   = cmd_valid && cmd_code == 3'd2;
  wire c_rst_stale = cmd_valid && cmd_code == 3'd3;
  wire c_en_stale  = cmd_valid && cmd_code == 3'd4;
  wire c_dis_stale = cmd_valid && cmd_code == 3'd5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync  <= 3'b111;
      div_cnt  <= '0;
      st       <= S_IDLE;
      ph       <= '0;
      bitn     <= '0;
      sh       <= '0;
      chr_vld  <= 1'b0;
      ferr_evt <= 1'b0;
    end else begin
      rx_sync  <= {rx_sync[1:0], rxd};
      div_cnt  <= tick ? '0 : div_cnt + 1'b1;
      chr_vld  <= 1'b0;
      ferr_evt <= 1'b0;
      case (st)
        S_IDLE:  if (fall) begin st <= S_START; ph <= '0; end
        S_START: if (tick) begin
          if (ph == 4'd7) begin
            ph   <= '0;
            bitn <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else ph <= ph + 1'b1;
        end
        S_DATA:  if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 4'd15) begin
            sh   <= {rx_s, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= S_STOP;
          end
        end
        default: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 4'd15) begin
            chr_vld  <= rx_s;
            ferr_evt <= ~rx_s;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic [7:0]         idle_tick;
  logic [STALE_W-1:0] idle_chars;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_tick  <= '0;
      idle_chars <= '0;
    end else if (st != S_IDLE || len_wr) begin
      idle_tick  <= '0;
      idle_chars <= '0;
    end else if (tick) begin
      if (idle_tick == 8'(CHAR_TICKS - 1)) begin
        idle_tick <= '0;
        if (idle_chars != '1) idle_chars <= idle_chars + 1'b1;
      end else idle_tick <= idle_tick + 1'b1;
    end
  end

  logic [31:0]      mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0]   level;
  logic [31:0]      wbuf, nxt_buf;
  logic [1:0]       bidx;
  logic [LEN_W-1:0] cnt, len_q;
  logic             active, stale_en;

  wire full      = (level == (PTR_W+1)'(FIFO_DEPTH));
  wire accept    = chr_vld && active && !full;
  wire last      = accept && (cnt + 1'b1 == len_q);
  wire stale_evt = stale_en && active && cnt != '0 && stale_tmo != '0 && idle_chars == stale_tmo;
  wire push      = (accept && (bidx == 2'd3 || last)) || (stale_evt && bidx != 2'd0);
  wire pop       = rd_en && level != '0;

  always_comb begin
    nxt_buf = wbuf;
    nxt_buf[{bidx, 3'b000} +: 8] = sh;
  end

  always_ff @(posedge clk) begin
    if (push && !c_rst_rx) mem[wp] <= accept ? nxt_buf : wbuf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
      wbuf <= '0; bidx <= '0; cnt <= '0; len_q <= '0;
      active <= 1'b0; stale_en <= 1'b0;
      overrun <= 1'b0; framing_err <= 1'b0; stale_flag <= 1'b0;
      xfer_done <= 1'b0; snap_count <= '0;
    end else begin
      xfer_done <= last || stale_evt;
      if (last)           snap_count <= cnt + 1'b1;
      else if (stale_evt) snap_count <= cnt;

      if (c_rst_rx) begin
        wp <= '0; rp <= '0; level <= '0;
        wbuf <= '0; bidx <= '0; cnt <= '0;
      end else begin
        if (push) wp <= (wp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
        level <= level + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        if (len_wr) cnt <= '0;
        else if (accept) cnt <= cnt + 1'b1;
        if (push) begin
          wbuf <= '0;
          bidx <= '0;
        end else if (accept) begin
          wbuf <= nxt_buf;
          bidx <= bidx + 1'b1;
        end
      end

      if (len_wr) begin
        active <= 1'b1;
        len_q  <= len_val;
      end else if (last || stale_evt) active <= 1'b0;

      if (c_en_stale)       stale_en <= 1'b1;
      else if (c_dis_stale) stale_en <= 1'b0;

      if (stale_evt)   stale_flag <= 1'b1;
      if (c_rst_stale) stale_flag <= 1'b0;

      if (chr_vld && active && full) overrun <= 1'b1;
      if (ferr_evt)                  framing_err <= 1'b1;
      if (c_rst_err) begin
        overrun     <= 1'b0;
        framing_err <= 1'b0;
      end
    end
  end

  assign data_ready = (level != '0);
  assign rd_data    = mem[rp];
endmodule

// File: rtl/uart_rx_xfer_chk.sv
module uart_rx_xfer_chk #(
  parameter int LEN_W      = 10,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_code,
  input logic             data_ready,
  input logic             overrun,
  input logic             stale_flag,
  input logic             xfer_done,
  input logic [LEN_W-1:0] snap_count,
  input logic [LVL_W-1:0] level
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !xfer_done |-> $stable(snap_count)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun && !(cmd_valid && cmd_code == 3'd2) |=> overrun); // R9
  AST_STALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && cmd_code == 3'd3 |=> !stale_flag); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && cmd_code == 3'd1 |=> !data_ready); // R11
  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) level <= LVL_W'(FIFO_DEPTH)); // R8
endmodule

bind uart_rx_xfer uart_rx_xfer_chk #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(PTR_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .data_ready(data_ready), .overrun(overrun), .stale_flag(stale_flag),
  .xfer_done(xfer_done), .snap_count(snap_count), .level(level)
);

// File: tb/test_uart_rx_xfer.sv
module test_uart_rx_xfer;
  localparam int BIT = 64;

  logic        clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic        cmd_valid = 1'b0, len_wr = 1'b0, rd_en = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [9:0]  len_val = '0;
  logic [3:0]  stale_tmo = '0;
  logic [31:0] rd_data;
  logic        data_ready, overrun, framing_err, stale_flag, xfer_done;
  logic [9:0]  snap_count;
  int checks = 0, errors = 0, done_cnt = 0;

  always #4 clk = ~clk;

  uart_rx_xfer i_uart_rx_xfer (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .len_wr(len_wr), .len_val(len_val), .stale_tmo(stale_tmo), .rd_en(rd_en),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
    .framing_err(framing_err), .stale_flag(stale_flag), .xfer_done(xfer_done),
    .snap_count(snap_count)
  );

  always @(negedge clk) if (rst_n && xfer_done) done_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = '0;
  endtask

  task automatic arm(input int n, input bit en);
    cmd(3'd5);
    cmd(3'd3);
    @(negedge clk); len_wr = 1'b1; len_val = 10'(n);
    @(negedge clk); len_wr = 1'b0;
    if (en) cmd(3'd4);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good);
    @(negedge clk);
    rxd = 1'b0; wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clk(BIT); end
    rxd = good; wait_clk(BIT);
    rxd = 1'b1;
    if (!good) wait_clk(BIT);
  endtask

  task automatic pop_check(input string req, input logic [31:0] exp);
    check(req, {31'd0, data_ready}, 32'd1);
    check(req, rd_data, exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 data_ready", {31'd0, data_ready}, 32'd0);
    check("R12 status", {28'd0, overrun, framing_err, stale_flag, xfer_done}, 32'd0);
    check("R12 snap", {22'd0, snap_count}, 32'd0);
  endtask

  task automatic t_count();
    int d0 = done_cnt;
    arm(6, 1'b0);
    for (int i = 1; i <= 6; i++) send_byte(8'(i * 8'h11), 1'b1);
    wait_clk(4);
    check("R4 done pulse count", done_cnt - d0, 1);
    check("R4 snapshot", {22'd0, snap_count}, 32'd6);
    pop_check("R2 first word LSB first", 32'h44332211);
    pop_check("R4 partial word pushed", 32'h00006655);
    check("R8 empty after pops", {31'd0, data_ready}, 32'd0);
  endtask

  task automatic t_unarmed();
    send_byte(8'h77, 1'b1);
    wait_clk(4);
    check("R3 unarmed char dropped", {31'd0, data_ready}, 32'd0);
    arm(1, 1'b0);
    send_byte(8'h99, 1'b1);
    wait_clk(4);
    check("R3 count restarts", {22'd0, snap_count}, 32'd1);
    pop_check("R3 single char word", 32'h00000099);
  endtask

  task automatic t_glitch();
    int d0 = done_cnt;
    arm(1, 1'b0);
    @(negedge clk); rxd = 1'b0; wait_clk(16); rxd = 1'b1;
    wait_clk(700);
    check("R1 glitch ignored", {31'd0, data_ready}, 32'd0);
    check("R1 glitch no done", done_cnt - d0, 0);
    send_byte(8'h1E, 1'b1);
    wait_clk(4);
    pop_check("R1 bit order", 32'h0000001E);
  endtask

  task automatic t_stale();
    int d0 = done_cnt;
    stale_tmo = 4'd2;
    arm(10, 1'b1);
    for (int i = 0; i < 5; i++) send_byte(8'(8'hA1 + i), 1'b1);
    wait_clk(1000);
    check("R5 no stale before timeout", {31'd0, stale_flag}, 32'd0);
    wait_clk(400);
    check("R5 stale flag", {31'd0, stale_flag}, 32'd1);
    check("R5 done on stale", done_cnt - d0, 1);
    check("R5 snapshot", {22'd0, snap_count}, 32'd5);
    pop_check("R5 full word", 32'hA4A3A2A1);
    pop_check("R5 partial word pushed", 32'h000000A5);
    cmd(3'd3);
    check("R7 stale cleared", {31'd0, stale_flag}, 32'd0);
  endtask

  task automatic t_stale_off();
    int d0 = done_cnt;
    arm(10, 1'b0);
    send_byte(8'h31, 1'b1);
    send_byte(8'h32, 1'b1);
    wait_clk(3000);
    check("R6 no stale when disabled", {31'd0, stale_flag}, 32'd0);
    check("R6 no done when disabled", done_cnt - d0, 0);
    check("R6 partial kept", {31'd0, data_ready}, 32'd0);
    cmd(3'd1);
    arm(1, 1'b0);
    send_byte(8'h5A, 1'b1);
    wait_clk(4);
    check("R11 count cleared", {22'd0, snap_count}, 32'd1);
    pop_check("R11 partial dropped", 32'h0000005A);
  endtask

  task automatic t_overrun();
    arm(20, 1'b0);
    for (int i = 1; i <= 16; i++) send_byte(8'(i), 1'b1);
    wait_clk(4);
    check("R9 no overrun at full", {31'd0, overrun}, 32'd0);
    send_byte(8'h11, 1'b1);
    wait_clk(4);
    check("R9 overrun set", {31'd0, overrun}, 32'd1);
    pop_check("R9 word 0", 32'h04030201);
    pop_check("R9 word 1", 32'h08070605);
    pop_check("R9 word 2", 32'h0C0B0A09);
    pop_check("R9 word 3", 32'h100F0E0D);
    check("R9 lost char not stored", {31'd0, data_ready}, 32'd0);
    cmd(3'd2);
    check("R9 overrun cleared", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_frame();
    int d0 = done_cnt;
    arm(1, 1'b0);
    send_byte(8'h42, 1'b0);
    wait_clk(4);
    check("R10 framing set", {31'd0, framing_err}, 32'd1);
    check("R10 bad char dropped", {31'd0, data_ready}, 32'd0);
    check("R10 no done", done_cnt - d0, 0);
    send_byte(8'h43, 1'b1);
    wait_clk(4);
    pop_check("R10 next char ok", 32'h00000043);
    check("R10 framing sticky", {31'd0, framing_err}, 32'd1);
    cmd(3'd2);
    check("R10 framing cleared", {31'd0, framing_err}, 32'd0);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_count();
    t_unarmed();
    t_glitch();
    t_stale();
    t_stale_off();
    t_overrun();
    t_frame();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule